// File: doc/BRIEF.md
# Interrupt Exception Timing Sequencer

This block walks a CPU interrupt exception through its idle, bus-write and bus-read phases one clock at a time. A timing-accurate bus model uses it to know which phase the exception is in, whether the bus is being read or written, and the exact cycle in which the interrupt vector number is captured. A one-cycle accept strobe starts the sequence. An autovector flag selects between a short vector fetch, used when the vector is generated internally and must line up with a slow peripheral clock, and a longer fetch, used when an external controller drives the vector.

For autovectored interrupts, the sequencer waits for a phase of a divide-by-ten peripheral clock before it reads the vector. The phase count comes in on an input. Until the vector is captured, another accept strobe for the same interrupt marks it as pending again and replaces the held vector number. A fine mode counts every step with two-cycle resolution. A coarse mode rounds every step up to a multiple of four cycles.

The block has no data stream, so there are no valid/ready pins. Every pin is a plain control or status signal.

Top module: `exc_int_seq`

## Requirements
- R1: After reset, `busy`, `vec_strobe`, `done`, `bus_read` and `bus_write` are all 0, and `step_code` is 0.
- R2: If `irq_accept` is high while `busy` is low, `busy` goes high on the next cycle and the step sequence starts. `coarse_mode` and `irq_autovec` are captured at that edge. `step_code` then follows this order of codes: 1 first idle, 2 first penalty, 3 write PC low, 4 clock-sync wait, 5 vector read, 6 second idle, 7 second penalty, 8 write status, 9 write PC high, 10 read vector address high, 11 read vector address low, 12 first prefetch, 13 third idle, 14 third penalty, 15 final prefetch.
- R3: In fine mode the step lengths in cycles are 6, 2, 4, W, V, 4, 2, 4, 4, 4, 4, 4, 2, 2, 4. V is 10 for an autovectored interrupt and 12 otherwise, so the exception takes 46+V+W cycles (56 with W=0 and an autovector).
- R4: W is 0 for a vectored interrupt. For an autovectored one, the vector read starts in the first cycle, from the thirteenth busy cycle on, in which `eclk_phase` equals 0. W is capped at 8. `eclk_phase` must advance by one, modulo 10, on every clock.
- R5: In coarse mode each idle step absorbs the penalty that follows it and is rounded up to a multiple of 4 (8, 8 and 4 cycles). The penalty steps are skipped. The vector read takes 12 cycles and begins 12+W cycles after the start. The raw fine-mode wait is rounded up to 0, 4 or 8, and the whole exception takes 60+W cycles.
- R6: `bus_write` is high only in steps 3, 8 and 9. `bus_read` is high only in steps 5, 10, 11, 12 and 15. The two are never high together.
- R7: `vec_strobe` is high for exactly the last cycle of the vector read, and the step that follows is 6. From that cycle until the exception ends, `vec_num` does not change.
- R8: If `irq_accept` is high while `busy` is high in a cycle before the `vec_strobe` cycle, `irq_vec` replaces the held vector and `irq_repend` goes high. The flag stays high until the next exception starts.
- R9: If `irq_accept` is high during or after the `vec_strobe` cycle of a running exception, it does not restart the sequence, does not change `vec_num` and does not set `irq_repend`.
- R10: `done` is high for exactly the last cycle of the final prefetch, and in that cycle `done_cycles` equals the number of busy cycles. `busy` goes low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coarse_mode | input | 1 | 1 selects four-cycle-rounded timing; captured at start |
| irq_accept | input | 1 | Interrupt accept strobe; re-assertion while busy |
| irq_autovec | input | 1 | 1 means the vector is generated internally; captured at start |
| irq_vec | input | 8 | Vector number offered with the accept strobe |
| eclk_phase | input | 4 | Phase count (0 to 9) of the peripheral clock |
| busy | output | 1 | An exception sequence is running |
| step_code | output | 4 | Current step code (0 when idle) |
| bus_read | output | 1 | Current step reads the bus |
| bus_write | output | 1 | Current step writes the bus |
| vec_strobe | output | 1 | Vector number is captured in this cycle |
| vec_num | output | 8 | Held vector number |
| irq_repend | output | 1 | A re-assertion was taken before vector capture |
| done | output | 1 | Last cycle of the exception |
| done_cycles | output | 8 | Length of the exception in cycles, valid with done |

## Verification
The assertions check on every cycle that the bus read and write flags never overlap, that `done` lasts one cycle and is always followed by the end of `busy`, that `busy` starts only after an accept strobe, that the clock-sync wait can only go on to itself or to the vector read, and that the held vector stays frozen after the strobe. Cycle counts, the step in which the strobe falls for every peripheral-clock phase, the rounding in coarse mode, and whether a re-assertion lands just before or exactly on the capture cycle depend on the whole history of an exception. Only the bench's scenarios can show these, by comparing against lengths worked out from the step rules.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF    = 4'd0,
    ST_IDLE_A = 4'd1,
    ST_PEN_A  = 4'd2,
    ST_WPCL   = 4'd3,
    ST_EWAIT  = 4'd4,
    ST_VEC    = 4'd5,
    ST_IDLE_B = 4'd6,
    ST_PEN_B  = 4'd7,
    ST_WSR    = 4'd8,
    ST_WPCH   = 4'd9,
    ST_RVH    = 4'd10,
    ST_RVL    = 4'd11,
    ST_PF1    = 4'd12,
    ST_IDLE_C = 4'd13,
    ST_PEN_C  = 4'd14,
    ST_PF2    = 4'd15
  } step_t;

  function automatic int rnd4(input int x);
    return (x + 3) & ~3;
  endfunction

  function automatic logic is_pen(input step_t s);
    return (s == ST_PEN_A) || (s == ST_PEN_B) || (s == ST_PEN_C);
  endfunction

  function automatic logic is_wr(input step_t s);
    return (s == ST_WPCL) || (s == ST_WSR) || (s == ST_WPCH);
  endfunction

  function automatic logic is_rd(input step_t s);
    return (s == ST_VEC) || (s == ST_RVH) || (s == ST_RVL) ||
           (s == ST_PF1) || (s == ST_PF2);
  endfunction

endpackage

// File: rtl/exc_step_len.sv
module exc_step_len
  import exc_seq_pkg::*;
#(
  parameter int LW        = 5,
  parameter int IDLE_A    = 6,
  parameter int IDLE_B    = 4,
  parameter int IDLE_C    = 2,
  parameter int PEN       = 2,
  parameter int XFER      = 4,
  parameter int VEC_AUTO  = 10,
  parameter int VEC_EXT   = 12,
  parameter int VEC_CRS   = 12
) (
  input  step_t         step,
  input  logic          coarse,
  input  logic          autovec,
  output logic [LW-1:0] len
);

  localparam int CA = rnd4(IDLE_A + PEN);
  localparam int CB = rnd4(IDLE_B + PEN);
  localparam int CC = rnd4(IDLE_C + PEN);
  localparam int CX = rnd4(XFER);
  localparam int CV = rnd4(VEC_CRS);

  always_comb begin
    len = '0;
    unique case (step)
      ST_IDLE_A: len = coarse ? LW'(CA) : LW'(IDLE_A);
      ST_IDLE_B: len = coarse ? LW'(CB) : LW'(IDLE_B);
      ST_IDLE_C: len = coarse ? LW'(CC) : LW'(IDLE_C);
      ST_PEN_A, ST_PEN_B, ST_PEN_C:
                 len = coarse ? '0 : LW'(PEN);
      ST_VEC:    len = coarse ? LW'(CV) : (autovec ? LW'(VEC_AUTO) : LW'(VEC_EXT));
      ST_WPCL, ST_WSR, ST_WPCH, ST_RVH, ST_RVL, ST_PF1, ST_PF2:
                 len = coarse ? LW'(CX) : LW'(XFER);
      default:   len = '0;
    endcase
  end

endmodule

// File: rtl/exc_ewait.sv
module exc_ewait #(
  parameter int E_DIV   = 10,
  parameter int E_ALIGN = 0,
  parameter int E_MAX   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       coarse,
  input  logic [3:0] phase,
  output logic       skip,
  output logic       leave
);

  localparam int CW = $clog2(E_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] k;
  logic          seen_q;
  logic [3:0]    nph;
  logic          align_n;

  // phase value seen in the following cycle
  assign nph     = (phase == 4'(E_DIV - 1)) ? 4'd0 : phase + 4'd1;
  assign align_n = (nph == 4'(E_ALIGN));
  assign skip    = align_n;
  assign k       = cnt_q + CW'(1);

  always_comb begin
    leave = 1'b0;
    if (active) begin
      if (k == CW'(E_MAX))
        leave = 1'b1;
      else if (coarse)
        leave = (seen_q || align_n) && (k[1:0] == 2'b00);
      else
        leave = align_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= k;
      seen_q <= seen_q | align_n;
    end
  end

endmodule

// File: rtl/exc_vec_hold.sv
module exc_vec_hold #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          again,
  input  logic          stb,
  input  logic [VW-1:0] vec_in,
  output logic [VW-1:0] vec_q,
  output logic          rep_q
);

  logic locked_q;
  logic take;

  assign take = again && !locked_q && !stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q    <= '0;
      rep_q    <= 1'b0;
      locked_q <= 1'b0;
    end else if (start) begin
      vec_q    <= vec_in;
      rep_q    <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      if (take) begin
        vec_q <= vec_in;
        rep_q <= 1'b1;
      end
      if (stb)
        locked_q <= 1'b1;
    end
  end

endmodule

// File: rtl/exc_int_seq.sv
module exc_int_seq
  import exc_seq_pkg::*;
#(
  parameter int VW       = 8,
  parameter int TW       = 8,
  parameter int IDLE_A   = 6,
  parameter int IDLE_B   = 4,
  parameter int IDLE_C   = 2,
  parameter int PEN      = 2,
  parameter int XFER     = 4,
  parameter int VEC_AUTO = 10,
  parameter int VEC_EXT  = 12,
  parameter int VEC_CRS  = 12,
  parameter int E_DIV    = 10,
  parameter int E_ALIGN  = 0,
  parameter int E_MAX    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coarse_mode,
  input  logic          irq_accept,
  input  logic          irq_autovec,
  input  logic [VW-1:0] irq_vec,
  input  logic [3:0]    eclk_phase,
  output logic          busy,
  output logic [3:0]    step_code,
  output logic          bus_read,
  output logic          bus_write,
  output logic          vec_strobe,
  output logic [VW-1:0] vec_num,
  output logic          irq_repend,
  output logic          done,
  output logic [TW-1:0] done_cycles
);

  localparam int LW = 5;

  step_t         step_q, nxt;
  logic [LW-1:0] rem_q, len_nxt, len_go;
  logic          mode_q, auto_q;
  logic [TW-1:0] tot_q;
  logic          start, last, ew_active, ew_skip, ew_leave;

  assign busy      = (step_q != ST_OFF);
  assign start     = irq_accept && !busy;
  assign ew_active = (step_q == ST_EWAIT);
  assign last      = ew_active ? ew_leave : (rem_q == LW'(1));

  always_comb begin
    unique case (step_q)
      ST_WPCL: nxt = (auto_q && !ew_skip) ? ST_EWAIT : ST_VEC;
      ST_PF2:  nxt = ST_OFF;
      default: begin
        nxt = step_t'(step_q + 4'd1);
        if (mode_q && is_pen(nxt))
          nxt = step_t'(step_q + 4'd2);
      end
    endcase
  end

  exc_step_len #(
    .LW(LW), .IDLE_A(IDLE_A), .IDLE_B(IDLE_B), .IDLE_C(IDLE_C), .PEN(PEN),
    .XFER(XFER), .VEC_AUTO(VEC_AUTO), .VEC_EXT(VEC_EXT), .VEC_CRS(VEC_CRS)
  ) u_len_nxt (
    .step(nxt), .coarse(mode_q), .autovec(auto_q), .len(len_nxt)
  );

  exc_step_len #(
    .LW(LW), .IDLE_A(IDLE_A), .IDLE_B(IDLE_B), .IDLE_C(IDLE_C), .PEN(PEN),
    .XFER(XFER), .VEC_AUTO(VEC_AUTO), .VEC_EXT(VEC_EXT), .VEC_CRS(VEC_CRS)
  ) u_len_go (
    .step(ST_IDLE_A), .coarse(coarse_mode), .autovec(irq_autovec), .len(len_go)
  );

  exc_ewait #(
    .E_DIV(E_DIV), .E_ALIGN(E_ALIGN), .E_MAX(E_MAX)
  ) u_ewait (
    .clk(clk), .rst_n(rst_n), .active(ew_active), .coarse(mode_q),
    .phase(eclk_phase), .skip(ew_skip), .leave(ew_leave)
  );

  exc_vec_hold #(.VW(VW)) u_vec (
    .clk(clk), .rst_n(rst_n), .start(start), .again(irq_accept && busy),
    .stb(vec_strobe), .vec_in(irq_vec), .vec_q(vec_num), .rep_q(irq_repend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= ST_OFF;
      rem_q  <= '0;
      mode_q <= 1'b0;
      auto_q <= 1'b0;
      tot_q  <= '0;
    end else if (start) begin
      step_q <= ST_IDLE_A;
      rem_q  <= len_go;
      mode_q <= coarse_mode;
      auto_q <= irq_autovec;
      tot_q  <= TW'(1);
    end else if (busy) begin
      tot_q <= tot_q + TW'(1);
      if (last) begin
        step_q <= nxt;
        rem_q  <= len_nxt;
      end else if (!ew_active) begin
        rem_q  <= rem_q - LW'(1);
      end
    end
  end

  assign step_code   = step_q;
  assign bus_read    = is_rd(step_q);
  assign bus_write   = is_wr(step_q);
  assign vec_strobe  = (step_q == ST_VEC) && (rem_q == LW'(1));
  assign done        = (step_q == ST_PF2) && (rem_q == LW'(1));
  assign done_cycles = tot_q;

endmodule

// File: rtl/exc_int_seq_chk.sv
module exc_int_seq_chk #(
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_accept,
  input logic          busy,
  input logic [3:0]    step_code,
  input logic          bus_read,
  input logic          bus_write,
  input logic          vec_strobe,
  input logic [VW-1:0] vec_num,
  input logic          done
);

  logic stb_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) stb_seen_q <= 1'b0;
    else if (vec_strobe)  stb_seen_q <= 1'b1;
  end

  // R6
  bus_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_read && bus_write));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(irq_accept));

  // R4
  ewait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_code == 4'd4) |=> (step_code == 4'd4 || step_code == 4'd5));

  // R7
  strobe_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_strobe |=> (step_code == 4'd6));

  // R7
  vec_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_seen_q && busy) |-> $stable(vec_num));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

bind exc_int_seq exc_int_seq_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_accept(irq_accept), .busy(busy),
  .step_code(step_code), .bus_read(bus_read), .bus_write(bus_write),
  .vec_strobe(vec_strobe), .vec_num(vec_num), .done(done)
);

// File: tb/sim_exc_int_seq.sv
module sim_exc_int_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       coarse_mode, irq_accept, irq_autovec;
  logic [7:0] irq_vec;
  logic [3:0] eclk_phase;
  logic       busy, bus_read, bus_write, vec_strobe, irq_repend, done;
  logic [3:0] step_code;
  logic [7:0] vec_num, done_cycles;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  exc_int_seq u0 (
    .clk(clk), .rst_n(rst_n), .coarse_mode(coarse_mode), .irq_accept(irq_accept),
    .irq_autovec(irq_autovec), .irq_vec(irq_vec), .eclk_phase(eclk_phase),
    .busy(busy), .step_code(step_code), .bus_read(bus_read), .bus_write(bus_write),
    .vec_strobe(vec_strobe), .vec_num(vec_num), .irq_repend(irq_repend),
    .done(done), .done_cycles(done_cycles)
  );

  // free-running divide-by-ten phase
  always @(posedge clk) begin
    if (!rst_n) eclk_phase <= 4'd3;
    else        eclk_phase <= (eclk_phase == 4'd9) ? 4'd0 : eclk_phase + 4'd1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_wait(input bit crs, input bit av, input int ph13);
    int raw;
    if (!av) return 0;
    raw = (10 - ph13) % 10;
    if (crs) return (raw == 0) ? 0 : ((raw <= 4) ? 4 : 8);
    return (raw > 8) ? 8 : raw;
  endfunction

  // ra: 0 none, -1 cycle before capture, -2 capture cycle, >0 absolute busy cycle
  task automatic run(input bit crs, input bit av, input int vec, input int ra_in, input int revec);
    int ph0, w, v, stb_exp, total, ra, expvec, sk, sv, dk, dc;
    bit exprep;
    string rq;
    @(negedge clk);
    coarse_mode = crs; irq_autovec = av; irq_vec = 8'(vec); irq_accept = 1'b1;
    ph0     = int'(eclk_phase);
    w       = exp_wait(crs, av, (ph0 + 13) % 10);
    v       = crs ? 12 : (av ? 10 : 12);
    stb_exp = 12 + w + v;
    total   = crs ? 60 + w : 46 + v + w;
    ra      = (ra_in == -1) ? stb_exp - 1 : (ra_in == -2) ? stb_exp : ra_in;
    if (ra > total) ra = 0;
    exprep  = (ra > 0) && (ra < stb_exp);
    expvec  = exprep ? revec : vec;
    rq      = crs ? "R5" : (av ? "R4" : "R3");
    sk = -1; sv = -1; dk = -1; dc = -1;
    for (int k = 1; k <= total + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        check(busy && step_code == 4'd1, "R2", int'(step_code), 1);
        check(!bus_read && !bus_write, "R6", int'(bus_read) + int'(bus_write), 0);
      end
      if (k == 9)
        check(step_code == 4'd3 && bus_write && !bus_read, "R6", int'(step_code), 3);
      if (vec_strobe) begin sk = k; sv = int'(vec_num); end
      if (done) begin dk = k; dc = int'(done_cycles); end
      if (k == total + 1)
        check(!busy, "R10", int'(busy), 0);
      irq_accept = (k == ra);
      irq_vec    = (k == ra) ? 8'(revec) : 8'(vec);
    end
    irq_accept = 1'b0;
    check(sk == stb_exp, rq, sk, stb_exp);
    check(sv == expvec, exprep ? "R8" : "R7", sv, expvec);
    check(dk == total, "R10", dk, total);
    check(dc == total, crs ? "R5" : "R3", dc, total);
    check(irq_repend == exprep, exprep ? "R8" : "R9", int'(irq_repend), int'(exprep));
    check(int'(vec_num) == expvec, "R9", int'(vec_num), expvec);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; coarse_mode = 1'b0; irq_accept = 1'b0; irq_autovec = 1'b0; irq_vec = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && step_code == 4'd0, "R1", int'(step_code), 0);
    check(!vec_strobe && !done && !bus_read && !bus_write, "R1",
          int'(vec_strobe) + int'(done) + int'(bus_read) + int'(bus_write), 0);

    // directed corner cases
    run(1'b0, 1'b0, 8'h40, 0, 0);            // R3 vectored, 58 cycles
    run(1'b0, 1'b1, 8'h1a, 0, 0);            // R4 autovector
    run(1'b1, 1'b0, 8'h45, 0, 0);            // R5 coarse vectored
    run(1'b1, 1'b1, 8'h1c, 0, 0);            // R5 coarse autovector
    run(1'b0, 1'b0, 8'h41, -1, 8'h46);       // R8 last allowed cycle
    run(1'b0, 1'b1, 8'h1a, -2, 8'h99);       // R9 capture cycle ignored
    run(1'b1, 1'b1, 8'h1c, 40, 8'h77);       // R9 late accept
    run(1'b0, 1'b1, 8'h1a, 3, 8'h1e);        // R8 early re-assertion
    for (int p = 0; p < 10; p++) begin       // R4 every phase offset
      idle(1);
      run(1'b0, 1'b1, 8'h1a + 8'(p), 0, 0);
    end

    // constrained random
    for (int i = 0; i < 40; i++) begin
      int ra;
      idle(int'($urandom % 4));
      ra = ($urandom % 3 == 0) ? 0 : 1 + int'($urandom % 64);
      run(1'($urandom), 1'($urandom), int'($urandom % 256), ra, int'($urandom % 256));
    end

    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

endmodule